// File: doc/BRIEF.md
# Two-Wire Bus Timeout Monitor

This block sits beside the protocol state machine of a two-wire bus slave. It samples the raw bus clock and bus data lines into the system clock domain. It flags the bus framing events: a Start is data falling while the bus clock is high, and a Stop is data rising while the bus clock is high. It also runs two watchdog counters. One measures how long the bus clock stays low. The other measures how long data stays low while the bus clock is high. That second case catches a failed device that pins the data line with the clock released.

When either watchdog reaches its limit, the block emits a one-cycle reset pulse. The slave state machine treats this pulse in the same way as a Stop: it abandons the transfer in progress and waits for a fresh Start. A separate level flag stays asserted while the stuck-data condition lasts. A busy indication tracks whether a transfer window is open: Start opens it, and a Stop or a timeout closes it. Both limits are parameters counted in system-clock cycles. The defaults give roughly 35 ms at 50 MHz, and a bench can choose short values.

Top module: `twb_timeout_mon`

## Requirements
- R1: Both bus lines pass through a two-flop synchronizer that resets to the idle (high) level. After reset, every output is low and no strobe appears while the lines stay high.
- R2: A falling data edge while the bus clock is high produces a one-cycle `start_o`. The pulse is visible in the third system-clock cycle after the line change.
- R3: A rising data edge while the bus clock is high produces a one-cycle `stop_o`.
- R4: Data edges while the bus clock is low produce no Start or Stop strobe. They do not restart or disturb the clock-low count.
- R5: A bus-clock low period of exactly `CLK_LOW_LIMIT` sampled cycles gives exactly one `timeout_o` pulse. A period of `CLK_LOW_LIMIT-1` cycles gives none.
- R6: The clock-low count restarts whenever the bus clock returns high. Two sub-limit low periods separated by a high period give no timeout.
- R7: Data held low while the bus clock is high for `DAT_LOW_LIMIT` sampled cycles gives exactly one `timeout_o` pulse and raises `stuck_o`. One cycle fewer gives neither.
- R8: `stuck_o` stays high while the stuck condition persists and clears once data goes high.
- R9: `busy_o` is set by a Start and cleared by a Stop or a timeout pulse. A repeated Start while busy strobes `start_o` again and keeps `busy_o` high.
- R10: `timeout_o` is a single-cycle pulse even when the offending low level continues far beyond the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_i | input | 1 | Raw bus clock line level |
| bdat_i | input | 1 | Raw bus data line level |
| start_o | output | 1 | One-cycle Start strobe |
| stop_o | output | 1 | One-cycle Stop strobe |
| timeout_o | output | 1 | One-cycle interface reset pulse from either watchdog |
| stuck_o | output | 1 | Data held low with clock high beyond the limit |
| busy_o | output | 1 | Transfer window open between Start and Stop/timeout |

## Verification
The assertions assume that the two bus inputs are levels that hold stable for at least a system-clock cycle. They also assume that each limit is at least two cycles, so the two watchdogs can never expire on adjacent cycles. The stimulus changes the lines only on the falling system-clock edge and holds every level for whole cycles. It keeps the Start-to-clock-low gap far below the data limit, except in the scenario that deliberately pins data low.

// File: rtl/twb_pkg.sv
package twb_pkg;
  localparam int LINE_CLK = 0;
  localparam int LINE_DAT = 1;
  localparam int N_LINES  = 2;

  typedef logic [N_LINES-1:0] lines_t;

  function automatic int cnt_width(input int limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/twb_line_sync.sv
module twb_line_sync #(
  parameter int WIDTH     = 2,
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= {WIDTH{RESET_VAL}};
    else     stg[0] <= raw_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= {WIDTH{RESET_VAL}};
      else     stg[s] <= stg[s-1];
    end
  end

  assign sync_o = stg[STAGES-1];
endmodule

// File: rtl/twb_cond_detect.sv
module twb_cond_detect (
  input  logic clk,
  input  logic rst,
  input  logic clk_s_i,
  input  logic dat_s_i,
  output logic start_o,
  output logic stop_o
);
  logic clk_q, dat_q;
  logic clk_steady_hi;

  assign clk_steady_hi = clk_s_i & clk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_q   <= 1'b1;
      dat_q   <= 1'b1;
      start_o <= 1'b0;
      stop_o  <= 1'b0;
    end else begin
      clk_q   <= clk_s_i;
      dat_q   <= dat_s_i;
      start_o <= clk_steady_hi &  dat_q & ~dat_s_i;
      stop_o  <= clk_steady_hi & ~dat_q &  dat_s_i;
    end
  end

  // R2/R3: framing strobes never coincide
  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(start_o && stop_o));
  // R4: a Start strobe needs the bus clock high when it was detected
  p_start_clk_hi_r4: assert property (@(posedge clk) disable iff (rst)
    start_o |-> $past(clk_s_i));
  // R2: strobe lasts one cycle
  p_start_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o);
endmodule

// File: rtl/twb_hold_timer.sv
module twb_hold_timer #(
  parameter int LIMIT = 1750000
) (
  input  logic clk,
  input  logic rst,
  input  logic cond_i,
  output logic expire_o,
  output logic held_o
);
  localparam int CW = twb_pkg::cnt_width(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
  localparam logic [CW-1:0] SAT  = CW'(LIMIT);

  logic [CW-1:0] cnt;
  logic          hit;

  assign hit = cond_i && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      expire_o <= 1'b0;
      held_o   <= 1'b0;
    end else begin
      expire_o <= hit;
      if (!cond_i) begin
        cnt    <= '0;
        held_o <= 1'b0;
      end else begin
        if (cnt != SAT) cnt <= cnt + 1'b1;
        if (hit) held_o <= 1'b1;
      end
    end
  end

  // R10: expiry is a single pulse per low episode
  p_single_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    expire_o |=> !expire_o);
  // R8: the held flag only rises together with an expiry
  p_held_rise_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(held_o) |-> expire_o);
  // R6: once the condition drops, the count has restarted
  p_restart_r6: assert property (@(posedge clk) disable iff (rst)
    !cond_i |=> (cnt == '0));
endmodule

// File: rtl/twb_timeout_mon.sv
module twb_timeout_mon #(
  parameter int CLK_LOW_LIMIT = 1750000,
  parameter int DAT_LOW_LIMIT = 1750000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bclk_i,
  input  logic bdat_i,
  output logic start_o,
  output logic stop_o,
  output logic timeout_o,
  output logic stuck_o,
  output logic busy_o
);
  import twb_pkg::*;

  lines_t raw, syn;
  logic   clk_exp, dat_exp, clk_held;
  logic   clk_low, dat_pinned;

  assign raw[LINE_CLK] = bclk_i;
  assign raw[LINE_DAT] = bdat_i;

  twb_line_sync #(.WIDTH(N_LINES), .STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .raw_i(raw), .sync_o(syn));

  twb_cond_detect u_det (
    .clk(clk), .rst(rst),
    .clk_s_i(syn[LINE_CLK]), .dat_s_i(syn[LINE_DAT]),
    .start_o(start_o), .stop_o(stop_o));

  assign clk_low    = ~syn[LINE_CLK];
  assign dat_pinned =  syn[LINE_CLK] & ~syn[LINE_DAT];

  twb_hold_timer #(.LIMIT(CLK_LOW_LIMIT)) u_clk_tmr (
    .clk(clk), .rst(rst), .cond_i(clk_low),
    .expire_o(clk_exp), .held_o(clk_held));

  twb_hold_timer #(.LIMIT(DAT_LOW_LIMIT)) u_dat_tmr (
    .clk(clk), .rst(rst), .cond_i(dat_pinned),
    .expire_o(dat_exp), .held_o(stuck_o));

  assign timeout_o = clk_exp | dat_exp;

  always_ff @(posedge clk) begin
    if (rst)                       busy_o <= 1'b0;
    else if (start_o)              busy_o <= 1'b1;
    else if (stop_o || timeout_o)  busy_o <= 1'b0;
  end

  // R10: the two watchdogs never expire together
  p_one_source_r10: assert property (@(posedge clk) disable iff (rst)
    !(clk_exp && dat_exp));
  // R9: a Stop closes the transfer window
  p_stop_idle_r9: assert property (@(posedge clk) disable iff (rst)
    stop_o |=> !busy_o);
  // R9: a Start opens it
  p_start_busy_r9: assert property (@(posedge clk) disable iff (rst)
    start_o |=> busy_o);
  // R7: the stuck flag rises only with a timeout pulse
  p_stuck_timeout_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(stuck_o) |-> timeout_o);
  // R5: a clock-low expiry cannot occur while the clock-low hold flag is set from before
  p_clk_once_r5: assert property (@(posedge clk) disable iff (rst)
    clk_exp |-> !$past(clk_held));
endmodule

// File: tb/twb_timeout_mon_tb_top.sv
module twb_timeout_mon_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LCLK = 40;
  localparam int LDAT = 30;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bclk = 1'b1;
  logic bdat = 1'b1;
  logic start_o, stop_o, timeout_o, stuck_o, busy_o;

  int checks = 0;
  int errors = 0;
  int n_start = 0, n_stop = 0, n_to = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  twb_timeout_mon #(.CLK_LOW_LIMIT(LCLK), .DAT_LOW_LIMIT(LDAT)) dut_i (
    .clk(clk), .rst(rst), .bclk_i(bclk), .bdat_i(bdat),
    .start_o(start_o), .stop_o(stop_o), .timeout_o(timeout_o),
    .stuck_o(stuck_o), .busy_o(busy_o));

  always @(negedge clk) begin
    if (!rst) begin
      n_start += int'(start_o);
      n_stop  += int'(stop_o);
      n_to    += int'(timeout_o);
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    cyc(8);
    check("R1 start", int'(start_o), 0);
    check("R1 stop", int'(stop_o), 0);
    check("R1 timeout", int'(timeout_o), 0);
    check("R1 stuck", int'(stuck_o), 0);
    check("R1 busy", int'(busy_o), 0);
    check("R1 no strobes", n_start + n_stop + n_to, 0);
  endtask

  task automatic t_start_latency;
    int s0 = n_start;
    bdat = 1'b0;
    cyc(2); check("R2 not yet", int'(start_o), 0);
    cyc(1); check("R2 pulse", int'(start_o), 1);
    cyc(1); check("R2 one cycle", int'(start_o), 0);
    cyc(2); check("R2 count", n_start - s0, 1);
    check("R9 busy after start", int'(busy_o), 1);
    bclk = 1'b0; cyc(3);
  endtask

  task automatic t_data_while_low;
    int s0 = n_start, p0 = n_stop, t0 = n_to;
    bclk = 1'b1; cyc(4); bclk = 1'b0;
    for (int i = 0; i < LCLK - 1; i++) begin
      bdat = ~bdat;
      cyc(1);
    end
    bclk = 1'b1; bdat = 1'b0; cyc(6);
    check("R4 no start", n_start - s0, 0);
    check("R4 no stop", n_stop - p0, 0);
    check("R4 no timeout", n_to - t0, 0);
    bclk = 1'b0; cyc(3);
  endtask

  task automatic t_clk_boundary;
    int t0 = n_to;
    bclk = 1'b1; cyc(4);
    bclk = 1'b0; cyc(LCLK - 1); bclk = 1'b1; cyc(6);
    check("R5 limit-1 no timeout", n_to - t0, 0);
    bclk = 1'b0; cyc(LCLK - 1); bclk = 1'b1; cyc(2);
    bclk = 1'b0; cyc(LCLK - 1); bclk = 1'b1; cyc(6);
    check("R6 restart on high", n_to - t0, 0);
    bclk = 1'b0; cyc(LCLK); bclk = 1'b1; cyc(6);
    check("R5 exact limit", n_to - t0, 1);
    check("R9 busy cleared by timeout", int'(busy_o), 0);
  endtask

  task automatic t_long_low;
    int t0 = n_to;
    bclk = 1'b0; cyc(4 * LCLK);
    check("R10 single pulse", n_to - t0, 1);
    bclk = 1'b1; cyc(6);
  endtask

  task automatic t_stop_repeat;
    int s0, p0;
    bdat = 1'b1; bclk = 1'b1; cyc(6);
    s0 = n_start; p0 = n_stop;
    bdat = 1'b0; cyc(4); bclk = 1'b0; cyc(5);
    bdat = 1'b1; cyc(2); bclk = 1'b1; cyc(3);
    bdat = 1'b0; cyc(4); bclk = 1'b0; cyc(5);
    check("R9 repeated start", n_start - s0, 2);
    check("R9 busy held", int'(busy_o), 1);
    bclk = 1'b1; cyc(3); bdat = 1'b1; cyc(6);
    check("R3 stop count", n_stop - p0, 1);
    check("R9 idle after stop", int'(busy_o), 0);
  endtask

  task automatic t_stuck;
    int t0 = n_to;
    bclk = 1'b1; bdat = 1'b1; cyc(4);
    bdat = 1'b0; cyc(LDAT - 1); bclk = 1'b0; cyc(6);
    check("R7 limit-1 no timeout", n_to - t0, 0);
    check("R7 limit-1 no stuck", int'(stuck_o), 0);
    bdat = 1'b1; cyc(2); bclk = 1'b1; cyc(4);
    bdat = 1'b0; cyc(LDAT + 20);
    check("R7 stuck timeout", n_to - t0, 1);
    check("R8 stuck held", int'(stuck_o), 1);
    bdat = 1'b1; cyc(6);
    check("R8 stuck cleared", int'(stuck_o), 0);
  endtask

  initial begin
    cyc(4);
    rst = 1'b0;
    t_reset();
    t_start_latency();
    t_data_while_low();
    t_clk_boundary();
    t_long_low();
    t_stop_repeat();
    t_stuck();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule